// File: doc/BRIEF.md
# Buffered-Compare PWM Timer Channel

This block is one 16-bit timer channel that produces a pulse-width-modulated waveform on a single pin. An up-counter advances on each cycle where both the run input and the prescaled clock-enable are high. Compare slot B sets the period: the counter returns to zero when it equals B. Compare slot A sets the duty edge: the pin goes high when the counter equals A and goes low on each counter clear.

Each compare slot has a shadow (buffer) register next to its active register. Software can write the shadow at any time. When buffering is enabled for a slot, the shadow is copied into the active register at a chosen moment, so a duty or period change never produces a partial pulse. A mode bit picks that moment: the counter clear, or the compare match of the slot itself. All registers are loaded through a plain one-cycle write strobe. The block has no data stream, so it needs no valid/ready handshake.

Top module: `pwm_bufcmp_chan`

## Requirements
- R1: After reset the pin is 0, the counter is 0, the mode bits are 0 and all four compare registers hold 0xFFFF. With these values the pin stays 0 while the counter runs.
- R2: On an advancing cycle where the counter equals active B, the counter clears to 0. The pin therefore repeats every B+1 advancing cycles.
- R3: On an advancing cycle where the counter equals active A and no clear happens, the pin is set to 1. When A<B the pin is high for B-A advancing cycles of each period.
- R4: A clear drives the pin to 0 and wins over a match on A in the same cycle. When A>=B the pin never goes high.
- R5: The counter advances only on cycles where both `run` and `tick` are 1. Otherwise the counter and the pin hold their values.
- R6: With `tick` high on every other cycle, the period and the high time both double in clock cycles.
- R7: When mode bit 2 is 1 (reload at clear), each buffered slot copies its shadow into its active register on the clear cycle. The new A value takes effect from the next period, even if the old A never matched.
- R8: When mode bit 2 is 0 (reload at match), shadow A is copied into active A only on a match of A. If A never matches, nothing is copied. Shadow B is always copied on the clear, which is B's own match.
- R9: While buffering is enabled for a slot, a write to that slot's active register is ignored.
- R10: While buffering is disabled for a slot, a write to its active register takes effect directly, and a write to its shadow has no effect on the waveform.
- R11: The register addresses are: 0 = active A, 1 = active B, 2 = shadow A, 3 = shadow B, 4 = mode. In the mode register, bit 0 enables buffering for A, bit 1 enables buffering for B, and bit 2 selects reload at clear. A write takes effect at the clock edge where `wr_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (R11) |
| wr_data | input | 16 | Write data |
| run | input | 1 | Start bit: the counter may advance while 1 |
| tick | input | 1 | Prescaled clock-enable |
| pwm_o | output | 1 | PWM pin |

## Verification
The pin is a register. It changes exactly one clock after the advancing edge where the counter equals A or B, so high time and period appear directly as counts of sampled cycles. The bench samples at the falling clock edge. It measures pulse widths and rise-to-rise intervals, or it counts high samples over a window of exactly three periods, so phase alignment does not matter. Register writes take effect at the next rising edge, and buffered values show up in the first pulse after the copy event, so each reload check measures the specific pulse where the new value is due.

// File: rtl/pwmb_pkg.sv
package pwmb_pkg;
  localparam int unsigned SLOTS  = 2;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADR_ACT_A  = 3'd0,
    ADR_ACT_B  = 3'd1,
    ADR_SHD_A  = 3'd2,
    ADR_SHD_B  = 3'd3,
    ADR_MODE   = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic reload_on_clear;
    logic shadow_b_en;
    logic shadow_a_en;
  } mode_t;
endpackage

// File: rtl/pwmb_counter.sv
module pwmb_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  assign wrap = step && (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (step)     cnt <= wrap ? '0 : cnt + 1'b1;
  end

  a_r2_clear_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt == limit) |=> (cnt == '0));
  a_r2_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt != limit) |=> (cnt == $past(cnt) + 1'b1));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt));
endmodule

// File: rtl/pwmb_slot.sv
module pwmb_slot #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_act,
  input  logic         wr_shd,
  input  logic [W-1:0] wdata,
  input  logic         shd_en,
  input  logic         xfer,
  output logic [W-1:0] act,
  output logic [W-1:0] shd
);
  always_ff @(posedge clk) begin
    if (!rst_n)                 act <= '1;
    else if (shd_en && xfer)    act <= shd;
    else if (wr_act && !shd_en) act <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      shd <= '1;
    else if (wr_shd) shd <= wdata;
  end

  a_r9_locked_active: assert property (@(posedge clk) disable iff (!rst_n)
    (shd_en && !xfer) |=> $stable(act));
  a_r7_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (shd_en && xfer) |=> (act == $past(shd)));
  a_r10_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (!shd_en && wr_act) |=> (act == $past(wdata)));
endmodule

// File: rtl/pwmb_pin.sv
module pwmb_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pin_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     pin_o <= 1'b0;
    else if (clr_i) pin_o <= 1'b0;
    else if (set_i) pin_o <= 1'b1;
  end

  a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !pin_o);
  a_r3_set: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> pin_o);
  a_r5_pin_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_i || clr_i) |=> $stable(pin_o));
endmodule

// File: rtl/pwm_bufcmp_chan.sv
module pwm_bufcmp_chan
  import pwmb_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              run,
  input  logic              tick,
  output logic              pwm_o
);
  localparam int unsigned SHD_BASE = int'(ADR_SHD_A);

  mode_t            mode_q;
  logic             step;
  logic             wrap;
  logic             hit_a;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] act   [SLOTS];
  logic [CNT_W-1:0] shd   [SLOTS];
  logic             shd_en[SLOTS];
  logic             xfer  [SLOTS];

  assign step  = run && tick;
  assign hit_a = step && (cnt == act[0]) && !wrap;

  always_ff @(posedge clk) begin
    if (!rst_n)                              mode_q <= '0;
    else if (wr_en && wr_addr == ADR_MODE)   mode_q <= mode_t'(wr_data[$bits(mode_t)-1:0]);
  end

  assign shd_en[0] = mode_q.shadow_a_en;
  assign shd_en[1] = mode_q.shadow_b_en;
  assign xfer[0]   = mode_q.reload_on_clear ? wrap : hit_a;
  assign xfer[1]   = wrap;

  pwmb_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .limit (act[1]),
    .cnt   (cnt),
    .wrap  (wrap)
  );

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic sel_act, sel_shd;
    assign sel_act = wr_en && (wr_addr == ADDR_W'(i));
    assign sel_shd = wr_en && (wr_addr == ADDR_W'(SHD_BASE + i));
    pwmb_slot #(.W(CNT_W)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_act (sel_act),
      .wr_shd (sel_shd),
      .wdata  (wr_data),
      .shd_en (shd_en[i]),
      .xfer   (xfer[i]),
      .act    (act[i]),
      .shd    (shd[i])
    );
  end

  pwmb_pin u_pin (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (hit_a),
    .clr_i (wrap),
    .pin_o (pwm_o)
  );

  a_r8_no_copy_without_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.shadow_a_en && !mode_q.reload_on_clear && !hit_a) |=> $stable(act[0]));
  a_r7_copy_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.shadow_a_en && mode_q.reload_on_clear && wrap) |=> (act[0] == $past(shd[0])));
  a_r1_reset_pin: assert property (@(posedge clk) !rst_n |=> !pwm_o);
endmodule

// File: tb/pwm_bufcmp_chan_tb.sv
module pwm_bufcmp_chan_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        run = 1'b0;
  logic        tick = 1'b1;
  logic        tick_alt = 1'b0;
  logic        pwm_o;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pwm_bufcmp_chan u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .run(run), .tick(tick), .pwm_o(pwm_o)
  );

  initial forever begin
    @(negedge clk);
    tick = tick_alt ? ~tick : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    run = 1'b0; wr_en = 1'b0; tick_alt = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_rise(output int t);
    logic p;
    p = pwm_o;
    t = -1;
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      if (pwm_o && !p) begin t = n + 1; return; end
      p = pwm_o;
    end
  endtask

  task automatic high_len(output int h);
    h = 0;
    while (pwm_o && h < 5000) begin
      @(negedge clk);
      h++;
    end
  endtask

  initial begin
    #1500000;
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int t, h, hi, rs, bad;
    logic p, ref_pin;

    // R1: reset state, pin stays low with 0xFFFF compares while running
    do_reset();
    chk(pwm_o == 1'b0, "R1 pin after reset", pwm_o, 0);
    run = 1'b1;
    bad = 0;
    repeat (40) begin @(negedge clk); if (pwm_o) bad++; end
    chk(bad == 0, "R1 pin low with reset compares", bad, 0);

    // R2/R3/R4/R11: sweep of A and B, unbuffered
    for (int b = 2; b <= 7; b++) begin
      for (int a = 0; a <= b + 1; a++) begin
        do_reset();
        wr(3'd0, 16'(a));
        wr(3'd1, 16'(b));
        run = 1'b1;
        repeat (2 * (b + 1)) @(negedge clk);
        hi = 0; rs = 0; p = pwm_o;
        for (int k = 0; k < 3 * (b + 1); k++) begin
          @(negedge clk);
          if (pwm_o) hi++;
          if (pwm_o && !p) rs++;
          p = pwm_o;
        end
        chk(hi == ((a < b) ? 3 * (b - a) : 0), "R3/R4 high cycles in 3 periods", hi, (a < b) ? 3 * (b - a) : 0);
        chk(rs == ((a < b) ? 3 : 0), "R2 rises in 3 periods", rs, (a < b) ? 3 : 0);
      end
    end

    // R2: rise-to-rise interval
    do_reset();
    wr(3'd0, 16'd1); wr(3'd1, 16'd7);
    run = 1'b1;
    wait_rise(t); wait_rise(t);
    chk(t == 8, "R2 period B+1", t, 8);

    // R6: tick every other cycle
    do_reset();
    wr(3'd0, 16'd1); wr(3'd1, 16'd5);
    tick_alt = 1'b1;
    run = 1'b1;
    wait_rise(t); wait_rise(t);
    chk(t == 12, "R6 period with half-rate tick", t, 12);
    high_len(h);
    chk(h == 8, "R6 high time with half-rate tick", h, 8);
    tick_alt = 1'b0;

    // R5: run low freezes pin, then resumes
    do_reset();
    wr(3'd0, 16'd2); wr(3'd1, 16'd9);
    run = 1'b1;
    wait_rise(t);
    run = 1'b0;
    ref_pin = pwm_o;
    bad = 0;
    repeat (40) begin @(negedge clk); if (pwm_o != ref_pin) bad++; end
    chk(bad == 0, "R5 pin frozen while run low", bad, 0);
    run = 1'b1;
    wait_rise(t); high_len(h);
    chk(h == 7, "R5 duty after resume", h, 7);

    // R7: reload at clear, A never matched before the copy
    do_reset();
    wr(3'd0, 16'd12); wr(3'd1, 16'd9); wr(3'd2, 16'd6);
    wr(3'd4, 16'h5);
    run = 1'b1;
    wait_rise(t);
    chk(t > 0, "R7 pulse appears after clear copy", t, 1);
    high_len(h);
    chk(h == 3, "R7 high time from copied A", h, 3);

    // R8: reload at match, A never matches, so no copy
    do_reset();
    wr(3'd0, 16'd12); wr(3'd1, 16'd9); wr(3'd2, 16'd6);
    wr(3'd4, 16'h1);
    run = 1'b1;
    wait_rise(t);
    chk(t == -1, "R8 no copy without match", t, -1);

    // R8: reload at match, copy after first match
    do_reset();
    wr(3'd0, 16'd2); wr(3'd1, 16'd9); wr(3'd2, 16'd6);
    wr(3'd4, 16'h1);
    run = 1'b1;
    wait_rise(t); high_len(h);
    chk(h == 7, "R8 first pulse uses old A", h, 7);
    wait_rise(t); high_len(h);
    chk(h == 3, "R8 second pulse uses copied A", h, 3);

    // R7: shadow B copied at clear
    do_reset();
    wr(3'd0, 16'd1); wr(3'd1, 16'd9); wr(3'd3, 16'd5);
    wr(3'd4, 16'h2);
    run = 1'b1;
    wait_rise(t); wait_rise(t);
    chk(t == 10, "R7 first period uses old B", t, 10);
    wait_rise(t);
    chk(t == 6, "R7 period after B copy", t, 6);

    // R9: direct write to buffered active A ignored
    do_reset();
    wr(3'd0, 16'd2); wr(3'd1, 16'd9); wr(3'd2, 16'd2);
    wr(3'd4, 16'h1);
    run = 1'b1;
    wr(3'd0, 16'd7);
    wait_rise(t); wait_rise(t); high_len(h);
    chk(h == 7, "R9 locked active A", h, 7);

    // R10: unbuffered shadow write no effect, direct write effective
    do_reset();
    wr(3'd0, 16'd3); wr(3'd1, 16'd9);
    run = 1'b1;
    wr(3'd2, 16'd8);
    wait_rise(t); wait_rise(t); high_len(h);
    chk(h == 6, "R10 shadow write ignored", h, 6);
    wr(3'd0, 16'd5);
    wait_rise(t); wait_rise(t); high_len(h);
    chk(h == 4, "R10 direct write to A", h, 4);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule